// File: doc/BRIEF.md
# Interrupt Event Router

This block gathers interrupt events and sends each one of two ways. The events come from internal event lines, from a local serial-error line, from a remote serial-error line, and from interrupt status words that arrive from the far end of a serial link. A routing control input picks the destination of local events. In one setting they set bits in a local status register, which drives a single interrupt line toward the processor. In the other setting they build up a status word for an outgoing interrupt packet, and a request output stays raised until the transmit side takes the word.

Software uses a small register window with four registers. One read-only register gives the highest-priority pending vector. One register clears status bits when 1s are written to it. One register sets status bits when 1s are written to it, for test. One register holds a pointer. A status word that arrives from the far end goes one of two ways, chosen by a second control input. It is either ORed into the local status register, or it is forwarded as a one-cycle write to the address held in the pointer register. The block does not encode packets and does not carry the serial transport.

Top module: `irq_router`

## Requirements
- R1: While `route_local_i` is 1, each source bit that is 1 in a cycle is set in the status register at the next clock edge. The packet status is left unchanged.
- R2: While `route_local_i` is 0, source bits go into the packet status (`pkt_status_o`) at the next edge. `pkt_req_o` is 1 whenever the packet status is nonzero. The status register is left unchanged.
- R3: The packet status keeps its bits and accumulates new ones until a cycle in which `pkt_ack_i` is 1. That cycle empties it, except for source bits that arrive in the same cycle, which are kept.
- R4: A received status word (`rx_valid_i`=1) with `rx_to_ptr_i`=0 is ORed into the status register at the next edge.
- R5: A received status word with `rx_to_ptr_i`=1 gives one cycle of `ptr_wr_o`=1 after the next edge. `ptr_data_o` carries the word and `ptr_addr_o` carries the pointer value held before that edge. The status register is left unchanged.
- R6: A read at address 0 returns the index of the lowest-numbered set status bit in bits [4:0], with all other bits 0. When no status bit is set, it returns 32'h8000_0000.
- R7: Writing at address 1 clears each status bit whose data bit is 1. Data bits that are 0 have no effect. Reads at addresses 1 and 2 return the status register.
- R8: Writing at address 2 sets each status bit whose data bit is 1.
- R9: When a bit is set and cleared in the same cycle, the bit is 1 after the edge.
- R10: `irq_o` is 1 exactly when at least one status bit is set.
- R11: `lerr_i` is source bit 30 and `rerr_i` is source bit 31. Both are ORed with the event lines and routed the same way.
- R12: After reset, the status register, the packet status and the pointer are all zero. A write at address 0 changes nothing. Address 3 reads and writes the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 32 | Internal event lines, one per vector |
| lerr_i | input | 1 | Local serial-error event |
| rerr_i | input | 1 | Remote serial-error event |
| route_local_i | input | 1 | 1: events go to local status; 0: events go to packet |
| pkt_ack_i | input | 1 | Transmit side has taken the packet status |
| pkt_req_o | output | 1 | Packet send request |
| pkt_status_o | output | 32 | Accumulated packet status word |
| rx_valid_i | input | 1 | Status word received from the far end |
| rx_status_i | input | 32 | Received status word |
| rx_to_ptr_i | input | 1 | 1: forward received word to the pointer target |
| ptr_wr_o | output | 1 | Forwarded write strobe |
| ptr_addr_o | output | 32 | Forwarded write address |
| ptr_data_o | output | 32 | Forwarded write data |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt toward the processor |

## Verification
A status bit that is wrongly held or wrongly dropped shows up one edge after the stimulus, at three places: the status readback, the vector readout and `irq_o`. A bit that leaks between the two routes appears in the wrong one of `pkt_status_o` and the status register in that same cycle. A packet status that is lost or stuck shows in `pkt_req_o` and `pkt_status_o` on the edge after the acknowledge. Every cycle, the bench compares all of these outputs against a model derived from the requirements.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  typedef enum logic [1:0] {
    SEL_VEC     = 2'd0,
    SEL_STATCLR = 2'd1,
    SEL_PENDSET = 2'd2,
    SEL_PTR     = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_mask_i,
  input  logic [W-1:0] clr_mask_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q;
  logic [W-1:0] stat_nxt;

  // set dominates clear
  function automatic logic [W-1:0] next_stat(input logic [W-1:0] cur,
                                              input logic [W-1:0] set_m,
                                              input logic [W-1:0] clr_m);
    return (cur & ~clr_m) | set_m;
  endfunction

  assign stat_nxt = next_stat(stat_q, set_mask_i, clr_mask_i);

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_nxt;
  end

  assign stat_o = stat_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(set_mask_i)) == $past(set_mask_i))); // R9
  AST_NO_SPURIOUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask_i == '0) |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R7
endmodule

// File: rtl/irq_pkt_accum.sv
module irq_pkt_accum #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_mask_i,
  input  logic         ack_i,
  output logic [W-1:0] pkt_o,
  output logic         req_o
);
  logic [W-1:0] pkt_q;
  logic [W-1:0] kept;

  assign kept = ack_i ? '0 : pkt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pkt_q <= '0;
    else        pkt_q <= kept | evt_mask_i;
  end

  assign pkt_o = pkt_q;
  assign req_o = |pkt_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i) |=> req_o); // R3
  AST_ACK_KEEPS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> (pkt_q == $past(evt_mask_i))); // R3
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req_i,
  output logic [W-1:0] vec_word_o
);
  localparam int IDX_W = $clog2(W);

  logic             any;
  logic [IDX_W-1:0] idx;

  // lowest index wins
  function automatic logic [IDX_W-1:0] first_set(input logic [W-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  assign any = |req_i;
  assign idx = first_set(req_i);

  always_comb begin
    vec_word_o = '0;
    if (any) vec_word_o[IDX_W-1:0] = idx;
    else     vec_word_o[W-1]       = 1'b1;
  end

  AST_VEC_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> req_i[idx]); // R6
  AST_VEC_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ((req_i & ((W'(1) << idx) - W'(1))) == '0)); // R6
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int LERR_BIT = DATA_W - 2,
  parameter int RERR_BIT = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] evt_i,
  input  logic              lerr_i,
  input  logic              rerr_i,
  input  logic              route_local_i,
  input  logic              pkt_ack_i,
  output logic              pkt_req_o,
  output logic [DATA_W-1:0] pkt_status_o,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_status_i,
  input  logic              rx_to_ptr_i,
  output logic              ptr_wr_o,
  output logic [DATA_W-1:0] ptr_addr_o,
  output logic [DATA_W-1:0] ptr_data_o,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] LERR_M = DATA_W'(1) << LERR_BIT;
  localparam logic [DATA_W-1:0] RERR_M = DATA_W'(1) << RERR_BIT;

  reg_sel_e sel;
  assign sel = reg_sel_e'(reg_addr_i);

  // named internal events
  logic [DATA_W-1:0] src_vec;
  logic [DATA_W-1:0] local_set;
  logic [DATA_W-1:0] remote_evt;
  logic [DATA_W-1:0] rx_set;
  logic [DATA_W-1:0] sw_set;
  logic [DATA_W-1:0] sw_clr;
  logic [DATA_W-1:0] set_mask;
  logic              rx_fwd;

  assign src_vec    = evt_i | (lerr_i ? LERR_M : '0) | (rerr_i ? RERR_M : '0);
  assign local_set  = route_local_i ? src_vec : '0;
  assign remote_evt = route_local_i ? '0 : src_vec;
  assign rx_fwd     = rx_valid_i && rx_to_ptr_i;
  assign rx_set     = (rx_valid_i && !rx_to_ptr_i) ? rx_status_i : '0;
  assign sw_set     = (reg_wr_i && sel == SEL_PENDSET) ? reg_wdata_i : '0;
  assign sw_clr     = (reg_wr_i && sel == SEL_STATCLR) ? reg_wdata_i : '0;
  assign set_mask   = local_set | rx_set | sw_set;

  logic [DATA_W-1:0] stat;
  logic [DATA_W-1:0] vec_word;

  irq_status_bank #(.W(DATA_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_mask_i (set_mask),
    .clr_mask_i (sw_clr),
    .stat_o     (stat)
  );

  irq_pkt_accum #(.W(DATA_W)) u_pkt (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_mask_i (remote_evt),
    .ack_i      (pkt_ack_i),
    .pkt_o      (pkt_status_o),
    .req_o      (pkt_req_o)
  );

  irq_prio_enc #(.W(DATA_W)) u_enc (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (stat),
    .vec_word_o (vec_word)
  );

  // pointer register and forwarded write
  logic [DATA_W-1:0] ptr_q;
  logic              fwd_q;
  logic [DATA_W-1:0] fwd_addr_q;
  logic [DATA_W-1:0] fwd_data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q      <= '0;
      fwd_q      <= 1'b0;
      fwd_addr_q <= '0;
      fwd_data_q <= '0;
    end else begin
      if (reg_wr_i && sel == SEL_PTR) ptr_q <= reg_wdata_i;
      fwd_q <= rx_fwd;
      if (rx_fwd) begin
        fwd_addr_q <= ptr_q;
        fwd_data_q <= rx_status_i;
      end
    end
  end

  assign ptr_wr_o   = fwd_q;
  assign ptr_addr_o = fwd_addr_q;
  assign ptr_data_o = fwd_data_q;

  always_comb begin
    unique case (sel)
      SEL_VEC:     reg_rdata_o = vec_word;
      SEL_STATCLR: reg_rdata_o = stat;
      SEL_PENDSET: reg_rdata_o = stat;
      SEL_PTR:     reg_rdata_o = ptr_q;
      default:     reg_rdata_o = '0;
    endcase
  end

  assign irq_o = |stat;

  AST_FWD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fwd |=> ptr_wr_o); // R5
  AST_FWD_NO_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fwd && !route_local_i && sw_set == '0 && sw_clr == '0) |=> $stable(stat)); // R5
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && set_mask == '0) |=> !irq_o); // R10
  AST_LOCAL_NO_PKT: assert property (@(posedge clk) disable iff (!rst_n)
    (route_local_i && !pkt_ack_i) |=> $stable(pkt_status_o)); // R1
endmodule

// File: tb/irq_router_bench.sv
module irq_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt_i = '0;
  logic        lerr_i = 1'b0, rerr_i = 1'b0, route_local_i = 1'b1, pkt_ack_i = 1'b0;
  logic        pkt_req_o;
  logic [31:0] pkt_status_o;
  logic        rx_valid_i = 1'b0, rx_to_ptr_i = 1'b0;
  logic [31:0] rx_status_i = '0;
  logic        ptr_wr_o;
  logic [31:0] ptr_addr_o, ptr_data_o;
  logic        reg_wr_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] m_stat = '0, m_pkt = '0, m_ptr = '0, m_faddr = '0, m_fdata = '0;
  logic        m_fwr = 1'b0;

  always #4 clk = ~clk;

  irq_router u_irq_router (.*);

  function automatic logic [31:0] exp_vec(input logic [31:0] s);
    for (int i = 0; i < 32; i++) if (s[i]) return 32'(i);
    return 32'h8000_0000;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag,
                     input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    reg_wr_i = 1'b0;
    reg_addr_i = 2'd1; #1; chk(reg_rdata_o, m_stat, tag, "status");
    reg_addr_i = 2'd2; #1; chk(reg_rdata_o, m_stat, tag, "pendset readback");
    reg_addr_i = 2'd0; #1; chk(reg_rdata_o, exp_vec(m_stat), tag, "vector");
    reg_addr_i = 2'd3; #1; chk(reg_rdata_o, m_ptr, tag, "pointer");
    chk(32'(irq_o), 32'(|m_stat), tag, "irq");
    chk(pkt_status_o, m_pkt, tag, "pkt status");
    chk(32'(pkt_req_o), 32'(|m_pkt), tag, "pkt req");
    chk(32'(ptr_wr_o), 32'(m_fwr), tag, "ptr wr");
    if (m_fwr) begin
      chk(ptr_addr_o, m_faddr, tag, "ptr addr");
      chk(ptr_data_o, m_fdata, tag, "ptr data");
    end
  endtask

  task automatic step(input logic [31:0] evt, input logic le, input logic re,
                      input logic rl, input logic ack, input logic rv,
                      input logic rp, input logic [31:0] rd, input logic wr,
                      input logic [1:0] a, input logic [31:0] wd, input string tag);
    logic [31:0] src, setm, clrm;
    @(negedge clk);
    evt_i = evt; lerr_i = le; rerr_i = re; route_local_i = rl; pkt_ack_i = ack;
    rx_valid_i = rv; rx_to_ptr_i = rp; rx_status_i = rd;
    reg_wr_i = wr; reg_addr_i = a; reg_wdata_i = wd;
    src  = evt | {re, le, 30'd0};
    setm = (rl ? src : 32'd0) | ((rv && !rp) ? rd : 32'd0) | ((wr && a == 2'd2) ? wd : 32'd0);
    clrm = (wr && a == 2'd1) ? wd : 32'd0;
    m_stat = (m_stat & ~clrm) | setm;
    m_pkt  = (ack ? 32'd0 : m_pkt) | (rl ? 32'd0 : src);
    m_fwr  = rv && rp;
    if (rv && rp) begin m_faddr = m_ptr; m_fdata = rd; end
    if (wr && a == 2'd3) m_ptr = wd;
    @(posedge clk); #1;
    evt_i = '0; lerr_i = 0; rerr_i = 0; pkt_ack_i = 0; rx_valid_i = 0; reg_wr_i = 0;
    check_all(tag);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1; check_all("R12 reset");
    step(32'h20, 0,0,1,0, 0,0,0, 0,0,0, "R1 local event");
    step(32'h208, 0,0,1,0, 0,0,0, 0,0,0, "R6 lowest vector");
    step(0, 0,0,1,0, 0,0,0, 1,2'd1,32'h0000_0008, "R7 w1c");
    step(32'h200, 0,0,1,0, 0,0,0, 1,2'd1,32'h200, "R9 set beats clear");
    step(0, 0,0,1,0, 0,0,0, 1,2'd2,32'h1, "R8 pendset");
    step(0, 0,0,1,0, 0,0,0, 1,2'd0,32'hFFFF_FFFF, "R12 vector write ignored");
    step(0, 1,1,1,0, 0,0,0, 1,2'd1,32'h0000_0221, "R11 error sources");
    step(0, 0,0,1,0, 0,0,0, 1,2'd1,32'hFFFF_FFFF, "R10 clear all irq low");
    step(32'h80, 0,0,0,0, 0,0,0, 0,0,0, "R2 remote event");
    step(32'h100, 0,1,0,0, 0,0,0, 0,0,0, "R3 accumulate");
    step(32'h4, 0,0,0,1, 0,0,0, 0,0,0, "R3 ack keeps new");
    step(0, 0,0,0,1, 0,0,0, 0,0,0, "R3 ack empties");
    step(0, 0,0,0,0, 0,0,0, 1,2'd3,32'h1234_0000, "R12 pointer write");
    step(0, 0,0,0,0, 1,1,32'hA5, 0,0,0, "R5 forward");
    step(0, 0,0,0,0, 1,0,32'h0001_0040, 0,0,0, "R4 rx to status");
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ev, rd, wd;
      logic [1:0] a;
      ev = ($urandom % 3 == 0) ? ($urandom & $urandom) : 32'd0;
      rd = $urandom; wd = $urandom & $urandom; a = 2'($urandom);
      step(ev, ($urandom % 8) == 0, ($urandom % 8) == 0, 1'($urandom), ($urandom % 4) == 0,
           ($urandom % 6) == 0, 1'($urandom), rd, ($urandom % 3) == 0, a, wd,
           "R1 R2 R3 R4 R5 R7 random");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
  end
endmodule